// File: doc/BRIEF.md
# Serial-In Parallel-Out Output Expander

This block lets a host controller drive twelve output pins over four wires: serial data, serial clock, strobe and an active-low clear. The host shifts bits in on rising edges of the serial clock. A 12-bit shift register collects them, and a 12-bit output register drives the pins.

The strobe decides what the output register does. While the strobe is high, the output register holds its value, so the host can load a new word without disturbing the pins. When the strobe falls, the output register takes the new word. While the strobe stays low, the output register follows every shift. Clear empties only the output register and has priority over the strobe. The shift register keeps its contents through a clear.

The block runs on a fast system clock. Each of the four pins passes through a two-stage synchronizer. A serial-clock rising edge is found by comparing the synchronized level with its value one cycle earlier, and the synchronized data bit is taken in that same cycle. The system reset is active high and clears both registers.

Top module: `sipo_expander`

## Requirements
- R1: While the system reset `rst` is high, the shift register and the output register are cleared, and `par_o` reads 0.
- R2: Each serial-clock rising edge shifts the data bit into `par_o` bit 0 side of the shift register, and the older bits move toward bit 11. After 12 edges, the first bit sent sits at `par_o[11]` (P12) and the last bit sent sits at `par_o[0]` (P1).
- R3: While `hold_i` is high and `clr_n_i` is high, `par_o` keeps its value even as serial-clock edges shift new bits in.
- R4: When `hold_i` goes from high to low, the current shift-register word appears on `par_o`.
- R5: While `hold_i` is low and `clr_n_i` is high, `par_o` follows each new shift-register word, no more than 4 system cycles after the serial-clock rising edge reaches the pin.
- R6: While `clr_n_i` is low, `par_o` is 0 for any level of `hold_i` and any serial-clock activity.
- R7: A clear does not change the shift register. After `clr_n_i` returns high, a strobe fall or a low strobe shows the word that was shifted in, including bits shifted during the clear.
- R8: Clear has priority over the strobe: with `hold_i` low and `clr_n_i` low, shifting does not reach `par_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high system reset, asynchronous assert |
| sdin_i | input | 1 | Serial data pin |
| sclk_i | input | 1 | Serial clock pin, shifts on a rising edge |
| hold_i | input | 1 | Strobe pin: high holds the outputs, low makes them follow |
| clr_n_i | input | 1 | Active-low clear of the output register |
| par_o | output | 12 | Parallel outputs, bit 0 is P1 and bit 11 is P12 |

## Verification
A missed or doubled shift leaves a word that is rotated by one or more places. This shows on `par_o` at the next strobe fall, or at once while the strobe is low. A clear that wrongly empties the shift register shows only later, on the first strobe after the clear is released. For that reason, the directed sequence strobes right after each clear. The bench's reference model is compared on every system clock, so a register update that is one cycle early or late shows on the same cycle.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

  // Index of each host pin inside the bundle that goes through the synchronizer
  localparam int PIN_DIN   = 0;
  localparam int PIN_SCLK  = 1;
  localparam int PIN_HOLD  = 2;
  localparam int PIN_CLR_N = 3;
  localparam int PIN_COUNT = 4;

  typedef enum logic [1:0] {
    LAT_CLEAR  = 2'd0,
    LAT_HOLD   = 2'd1,
    LAT_FOLLOW = 2'd2
  } latch_op_e;

  // Clear wins over strobe; a low strobe makes the output register follow
  function automatic latch_op_e pick_op(input logic clr_ok, input logic hold);
    if (!clr_ok)   return LAT_CLEAR;
    else if (hold) return LAT_HOLD;
    else           return LAT_FOLLOW;
  endfunction

endpackage

// File: rtl/sipo_sync.sv
module sipo_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);

  for (genvar b = 0; b < N; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  input  logic         din,
  output logic [W-1:0] sr_q
);

  // New bit enters at index 0, older bits move toward index W-1
  function automatic logic [W-1:0] push_bit(input logic [W-1:0] cur, input logic b);
    return {cur[W-2:0], b};
  endfunction

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       sr_q <= '0;
    else if (step) sr_q <= push_bit(sr_q, din);
  end

endmodule

// File: rtl/sipo_latch.sv
module sipo_latch
  import sipo_pkg::*;
#(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  latch_op_e    op,
  input  logic [W-1:0] src,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      q <= '0;
    end else begin
      unique case (op)
        LAT_CLEAR:  q <= '0;
        LAT_FOLLOW: q <= src;
        default:    q <= q;
      endcase
    end
  end

endmodule

// File: rtl/sipo_expander.sv
module sipo_expander
  import sipo_pkg::*;
#(
  parameter int WIDTH       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sdin_i,
  input  logic             sclk_i,
  input  logic             hold_i,
  input  logic             clr_n_i,
  output logic [WIDTH-1:0] par_o
);

  logic [PIN_COUNT-1:0] pins_raw;
  logic [PIN_COUNT-1:0] pins_s;
  logic                 din_s;
  logic                 sclk_s;
  logic                 hold_s;
  logic                 clr_s;
  logic                 sclk_prev;
  logic                 sclk_rise;
  logic [WIDTH-1:0]     sr_q;
  latch_op_e            lat_op;

  always_comb begin
    pins_raw            = '0;
    pins_raw[PIN_DIN]   = sdin_i;
    pins_raw[PIN_SCLK]  = sclk_i;
    pins_raw[PIN_HOLD]  = hold_i;
    pins_raw[PIN_CLR_N] = clr_n_i;
  end

  sipo_sync #(.N(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pins_raw),
    .q   (pins_s)
  );

  assign din_s  = pins_s[PIN_DIN];
  assign sclk_s = pins_s[PIN_SCLK];
  assign hold_s = pins_s[PIN_HOLD];
  assign clr_s  = pins_s[PIN_CLR_N];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;

  sipo_shifter #(.W(WIDTH)) u_shift (
    .clk  (clk),
    .rst  (rst),
    .step (sclk_rise),
    .din  (din_s),
    .sr_q (sr_q)
  );

  assign lat_op = pick_op(clr_s, hold_s);

  sipo_latch #(.W(WIDTH)) u_latch (
    .clk (clk),
    .rst (rst),
    .op  (lat_op),
    .src (sr_q),
    .q   (par_o)
  );

endmodule

// File: rtl/sipo_expander_chk.sv
module sipo_expander_chk #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             din_s,
  input logic             hold_s,
  input logic             clr_s,
  input logic             sclk_rise,
  input logic [WIDTH-1:0] sr_q,
  input logic [WIDTH-1:0] par_o
);

  // R1
  reset_zero_chk: assert property (@(posedge clk) rst |=> (par_o == '0 && sr_q == '0));

  // R2
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    sclk_rise |=> (sr_q[0] == $past(din_s) && sr_q[WIDTH-1:1] == $past(sr_q[WIDTH-2:0])));

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_s && hold_s) |=> $stable(par_o));

  // R4
  strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(hold_s) && clr_s) |=> (par_o == $past(sr_q)));

  // R5
  follow_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_s && !hold_s) |=> (par_o == $past(sr_q)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> (par_o == '0));

  // R7
  clear_keeps_sr_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !sclk_rise) |=> $stable(sr_q));

  // R8
  clear_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !hold_s && sclk_rise) |=> (par_o == '0));

endmodule

bind sipo_expander sipo_expander_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .din_s     (din_s),
  .hold_s    (hold_s),
  .clr_s     (clr_s),
  .sclk_rise (sclk_rise),
  .sr_q      (sr_q),
  .par_o     (par_o)
);

// File: tb/test_sipo_expander.sv
module test_sipo_expander;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdin = 1'b0;
  logic        sclk = 1'b0;
  logic        hold = 1'b1;
  logic        clr_n = 1'b1;
  logic [11:0] par;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2.5 clk = ~clk;

  sipo_expander i_sipo_expander (
    .clk     (clk),
    .rst     (rst),
    .sdin_i  (sdin),
    .sclk_i  (sclk),
    .hold_i  (hold),
    .clr_n_i (clr_n),
    .par_o   (par)
  );

  // Behavioural reference: pin history queue stands in for synchronizer latency
  logic [3:0]  hist[$];
  logic [11:0] ref_sr  = '0;
  logic [11:0] ref_out = '0;

  initial hist = '{4'b0, 4'b0, 4'b0};

  always @(posedge clk) begin
    logic [3:0]  seen;
    logic [3:0]  older;
    logic [11:0] old_sr;
    if (rst) begin
      hist    = '{4'b0, 4'b0, 4'b0};
      ref_sr  = '0;
      ref_out = '0;
    end else begin
      seen   = hist[1];   // {clr_n, hold, sclk, din} as the logic sees them now
      older  = hist[2];
      old_sr = ref_sr;
      if (!seen[3])     ref_out = '0;
      else if (!seen[2]) ref_out = old_sr;
      if (seen[1] && !older[1]) ref_sr = {old_sr[10:0], seen[0]};
      hist.push_front({clr_n, hold, sclk, sdin});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (par !== ref_out) begin
        n_fail++;
        $display("FAIL R5 model compare: par_o=%h expected %h at %0t", par, ref_out, $time);
      end
    end
  end

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdin = b;
    wait_n(3);
    sclk = 1'b1;
    wait_n(3);
    sclk = 1'b0;
    wait_n(3);
  endtask

  task automatic send_word(input logic [11:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
  endtask

  initial begin
    wait_n(4);
    check("R1 reset", par, 12'h000);
    rst = 1'b0;
    wait_n(4);
    check("R1 after reset", par, 12'h000);

    // R3: load a full word with strobe high, outputs must not move
    send_word(12'hA5C, 12);
    wait_n(6);
    check("R3 hold during load", par, 12'h000);

    // R4 and R2: strobe falls, word appears; first bit at P12, last at P1
    hold = 1'b0;
    wait_n(6);
    check("R4 strobe fall transfer", par, 12'hA5C);
    check("R2 first bit at P12", {11'b0, par[11]}, 12'h001);
    check("R2 last bit at P1", {11'b0, par[0]}, 12'h000);

    // R3 again: four more bits with strobe high
    hold = 1'b1;
    wait_n(4);
    send_word(12'h00A, 4);
    wait_n(6);
    check("R3 hold while shifting", par, 12'hA5C);
    hold = 1'b0;
    wait_n(6);
    check("R4 second transfer", par, 12'h5CA);

    // R5: strobe low, outputs follow each shift
    send_bit(1'b1);
    check("R5 follow bit 1", par, 12'hB95);
    send_bit(1'b0);
    check("R5 follow bit 0", par, 12'h72A);
    send_bit(1'b1);
    check("R5 follow bit 1 again", par, 12'hE55);

    // R6 with strobe high, then R7: release clear and strobe
    hold  = 1'b1;
    wait_n(4);
    clr_n = 1'b0;
    wait_n(6);
    check("R6 clear with strobe high", par, 12'h000);
    clr_n = 1'b1;
    wait_n(6);
    check("R6 stays clear while held", par, 12'h000);
    hold = 1'b0;
    wait_n(6);
    check("R7 shift register kept through clear", par, 12'hE55);

    // R8: clear low, strobe low, shifting does not reach the outputs
    clr_n = 1'b0;
    wait_n(6);
    check("R6 clear with strobe low", par, 12'h000);
    send_bit(1'b0);
    wait_n(4);
    check("R8 clear beats strobe", par, 12'h000);
    clr_n = 1'b1;
    wait_n(6);
    check("R7 shift during clear kept", par, 12'hCAA);

    wait_n(4);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule